// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block sits between a clocked host and an asynchronous static RAM of 8K words by 8 bits. The host issues one word per request, read or write, over a valid/ready port. The controller turns each accepted request into a pin-level RAM cycle. It drives the address, a pair of chip selects of opposite polarity, an active-low output enable, an active-low write enable and a tri-state data bus, which is split into an output value, an output-enable and an input sample. Every timing margin is a parameter counted in clock cycles, so that one netlist fits any clock rate and any RAM speed grade.

A write runs through four phases. First the address settles with the device selected. Then the write pulse is applied with the data driven. Then comes one guard cycle in which data is still driven after the write strobe rises. Last, the device is deselected for a turnaround gap. A read runs through the address settling phase, then an output-enable window of programmed length, then the turnaround gap. The read word is captured on the clock edge that closes the window. The host receives it as a one-cycle response in the next cycle. Only one request is in flight at a time. Every margin parameter must be at least one.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: During reset and right after it, both chip selects are inactive (`mem_ce_n`=1, `mem_ce`=0), `mem_oe_n`=1, `mem_we_n`=1, `mem_dq_oe`=0, `rsp_valid`=0 and `req_ready`=1.
- R2: `req_ready` is high only while no request is in flight. A request is taken at a rising edge where `req_valid` and `req_ready` are both high. Changes to the request inputs after that edge have no effect on the cycle in progress.
- R3: Whenever the device is selected, both chip selects are active together and `mem_addr` equals the accepted address, unchanged from one cycle to the next.
- R4: Each cycle begins with exactly SETUP_CYC clock cycles in which the device is selected and both strobes are high. No strobe falls unless the device was selected in the cycle before.
- R5: A write holds `mem_we_n` low for exactly PULSE_CYC consecutive cycles and keeps `mem_oe_n` high throughout.
- R6: During a write, `mem_dq_oe` is high with `mem_dq_out` equal to the accepted data for exactly PULSE_CYC+1 cycles. These are the write-pulse cycles plus one guard cycle after `mem_we_n` rises. The device is deselected right after the guard cycle.
- R7: A read holds `mem_oe_n` low for exactly ACCESS_CYC consecutive cycles with `mem_we_n` high. `mem_dq_oe` is never high while `mem_oe_n` is low.
- R8: The read word is the value on `mem_dq_in` at the edge that ends the last output-enable cycle. It appears on `rsp_rdata` with `rsp_valid` high for exactly one cycle, the first cycle after `mem_oe_n` rises. Writes produce no response.
- R9: After the strobe phase (reads) or the guard cycle (writes), the device stays deselected for TURN_CYC cycles before `req_ready` rises. A write therefore occupies SETUP_CYC+PULSE_CYC+1+TURN_CYC busy cycles, and a read occupies SETUP_CYC+ACCESS_CYC+TURN_CYC.
- R10: `mem_oe_n` and `mem_we_n` are never low together, and neither is low while the device is deselected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle, request will be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (13) | Word address |
| req_wdata | input | DATA_W (8) | Write data |
| rsp_valid | output | 1 | One-cycle read response strobe |
| rsp_rdata | output | DATA_W (8) | Read data |
| mem_addr | output | ADDR_W (13) | RAM address pins |
| mem_ce_n | output | 1 | Active-low chip select |
| mem_ce | output | 1 | Active-high chip select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_dq_oe | output | 1 | Drive enable for the shared data bus |
| mem_dq_out | output | DATA_W (8) | Value driven onto the data bus |
| mem_dq_in | input | DATA_W (8) | Value sampled from the data bus |

## Verification
The two events that can fall in the same cycle are the read response of one cycle and a pending host request that waits for the controller to go idle. The turnaround gap also overlaps the point where a new cycle could begin.

The bench provokes this overlap by holding `req_valid` high with the fields of the next request across a whole read. It then judges three things: that the response pulse arrives during the busy window with the right word, that `req_ready` stays low for exactly the read's busy length, and that the held request then starts on the next edge with the correct address-settling phase.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_SETUP  = 3'd1,
    PH_STROBE = 3'd2,
    PH_GUARD  = 3'd3,
    PH_TURN   = 3'd4
  } phase_e;

  // Number of clock cycles spent in a phase for a given cycle kind.
  function automatic int unsigned phase_len(input phase_e ph, input logic wr,
                                            input int unsigned setup_c,
                                            input int unsigned pulse_c,
                                            input int unsigned access_c,
                                            input int unsigned turn_c);
    case (ph)
      PH_SETUP:  return setup_c;
      PH_STROBE: return wr ? pulse_c : access_c;
      PH_TURN:   return turn_c;
      default:   return 1;
    endcase
  endfunction

  function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  function automatic int unsigned ctr_bits(input int unsigned maxv);
    return (maxv < 2) ? 1 : $clog2(maxv);
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int unsigned CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned SETUP_CYC  = 1,
  parameter int unsigned PULSE_CYC  = 3,
  parameter int unsigned ACCESS_CYC = 3,
  parameter int unsigned TURN_CYC   = 1,
  parameter int unsigned CW         = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          phase_done,
  output phase_e        phase,
  output logic          is_wr,
  output logic          accept,
  output logic          load,
  output logic [CW-1:0] load_val,
  output logic          capture_evt
);

  phase_e nxt;
  logic   wr_nxt;

  always_comb begin
    nxt    = phase;
    wr_nxt = is_wr;
    case (phase)
      PH_IDLE:   if (req_valid) begin nxt = PH_SETUP; wr_nxt = req_write; end
      PH_SETUP:  if (phase_done) nxt = PH_STROBE;
      PH_STROBE: if (phase_done) nxt = is_wr ? PH_GUARD : PH_TURN;
      PH_GUARD:  nxt = PH_TURN;
      PH_TURN:   if (phase_done) nxt = PH_IDLE;
      default:   nxt = PH_IDLE;
    endcase
  end

  assign accept      = (phase == PH_IDLE) && req_valid;
  assign load        = (nxt != phase);
  assign load_val    = CW'(phase_len(nxt, wr_nxt, SETUP_CYC, PULSE_CYC,
                                     ACCESS_CYC, TURN_CYC) - 1);
  assign capture_evt = (phase == PH_STROBE) && !is_wr && phase_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      is_wr <= 1'b0;
    end else begin
      phase <= nxt;
      is_wr <= wr_nxt;
    end
  end

endmodule

// File: rtl/sram_data_path.sv
module sram_data_path #(
  parameter int unsigned AW = 13,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          capture_evt,
  input  logic [DW-1:0] dq_in,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] wdata_q,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q    <= '0;
      wdata_q   <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      rsp_valid <= capture_evt;
      if (capture_evt) rsp_rdata <= dq_in;
    end
  end

endmodule

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W     = 13,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned SETUP_CYC  = 1,
  parameter int unsigned PULSE_CYC  = 3,
  parameter int unsigned ACCESS_CYC = 3,
  parameter int unsigned TURN_CYC   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_ce,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic              mem_dq_oe,
  output logic [DATA_W-1:0] mem_dq_out,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int unsigned MAX_LEN = max4(SETUP_CYC, PULSE_CYC, ACCESS_CYC, TURN_CYC);
  localparam int unsigned CW      = ctr_bits(MAX_LEN);

  phase_e          phase;
  logic            is_wr;
  logic            accept;
  logic            load;
  logic [CW-1:0]   load_val;
  logic            phase_done;
  logic            capture_evt;
  logic            selected;
  logic            strobe_on;

  sram_seq_fsm #(
    .SETUP_CYC (SETUP_CYC),
    .PULSE_CYC (PULSE_CYC),
    .ACCESS_CYC(ACCESS_CYC),
    .TURN_CYC  (TURN_CYC),
    .CW        (CW)
  ) fsm_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .phase_done (phase_done),
    .phase      (phase),
    .is_wr      (is_wr),
    .accept     (accept),
    .load       (load),
    .load_val   (load_val),
    .capture_evt(capture_evt)
  );

  sram_phase_timer #(.CW(CW)) timer_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .load_val(load_val),
    .done    (phase_done)
  );

  sram_data_path #(.AW(ADDR_W), .DW(DATA_W)) data_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .capture_evt(capture_evt),
    .dq_in      (mem_dq_in),
    .addr_q     (mem_addr),
    .wdata_q    (mem_dq_out),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata)
  );

  // Pin decode from registered phase state.
  assign selected  = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_GUARD);
  assign strobe_on = (phase == PH_STROBE);
  assign req_ready = (phase == PH_IDLE);
  assign mem_ce_n  = !selected;
  assign mem_ce    = selected;
  assign mem_we_n  = !(strobe_on && is_wr);
  assign mem_oe_n  = !(strobe_on && !is_wr);
  assign mem_dq_oe = is_wr && (strobe_on || (phase == PH_GUARD));

endmodule

// File: rtl/sram_cycle_ctrl_chk.sv
module sram_cycle_ctrl_chk #(
  parameter int unsigned AW = 13
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          mem_ce_n,
  input logic          mem_ce,
  input logic          mem_oe_n,
  input logic          mem_we_n,
  input logic          mem_dq_oe,
  input logic [AW-1:0] mem_addr,
  input logic          capture_evt
);

  logic sel;
  assign sel = mem_ce && !mem_ce_n;

  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));

  // R10
  strobe_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n || !mem_oe_n) |-> sel);

  // R7
  bus_conflict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_dq_oe);

  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && $past(sel)) |-> $stable(mem_addr));

  // R4
  strobe_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(mem_we_n) || $fell(mem_oe_n)) |-> $past(sel));

  // R6
  guard_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mem_we_n) && sel) |-> mem_dq_oe);

  // R8
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R8
  capture_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capture_evt |-> !mem_oe_n);

  // R8
  capture_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capture_evt |=> rsp_valid);

  // R2
  ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

endmodule

bind sram_cycle_ctrl sram_cycle_ctrl_chk #(.AW(ADDR_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .mem_ce_n   (mem_ce_n),
  .mem_ce     (mem_ce),
  .mem_oe_n   (mem_oe_n),
  .mem_we_n   (mem_we_n),
  .mem_dq_oe  (mem_dq_oe),
  .mem_addr   (mem_addr),
  .capture_evt(capture_evt)
);

// File: tb/sram_cycle_ctrl_tb_top.sv
`timescale 1ns/1ps
module sram_cycle_ctrl_tb_top;

  localparam int S = 2, P = 3, A = 4, T = 2;
  localparam int WR_BUSY = S + P + 1 + T;
  localparam int RD_BUSY = S + A + T;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [12:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [7:0]  rsp_rdata;
  logic [12:0] mem_addr;
  logic        mem_ce_n, mem_ce, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [7:0]  mem_dq_out, mem_dq_in;

  int tests = 0, fails = 0;

  always #2.5 clk = ~clk;

  sram_cycle_ctrl #(.SETUP_CYC(S), .PULSE_CYC(P), .ACCESS_CYC(A), .TURN_CYC(T)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_ce(mem_ce), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_dq_oe(mem_dq_oe), .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in)
  );

  // Behavioural RAM: low 8 address bits index the model (test addresses differ there).
  logic [7:0] model_mem [256];
  assign mem_dq_in = (mem_ce && !mem_ce_n && !mem_oe_n && mem_we_n)
                     ? model_mem[mem_addr[7:0]] : 8'hzz;
  always @(posedge mem_we_n)
    if (mem_ce === 1'b1 && mem_ce_n === 1'b0)
      model_mem[mem_addr[7:0]] = mem_dq_oe ? mem_dq_out : 8'hxx;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic issue(input bit wr, input logic [12:0] a, input logic [7:0] d);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
  endtask

  // Called at the first negedge after the accepting edge.
  task automatic observe(input bit wr, input logic [12:0] a, input logic [7:0] d);
    int busy = 0, sel_n = 0, we_n = 0, oe_n = 0, dq_n = 0, rsp_n = 0;
    int last_we = -1, last_oe = -1, last_dq = -1, last_sel = -1, rsp_at = -1;
    bit addr_ok = 1, pair_ok = 1, dq_ok = 1, conflict = 0, first_ok;
    logic [7:0] got = '0;
    req_valid = 1'b0; req_addr = ~a; req_wdata = ~d; req_write = !wr;
    first_ok = (mem_ce === 1'b1) && (mem_ce_n === 1'b0) && (mem_we_n === 1'b1)
               && (mem_oe_n === 1'b1);
    do begin
      if (mem_ce !== ~mem_ce_n) pair_ok = 0;
      if (mem_ce === 1'b1) begin
        sel_n++; last_sel = busy;
        if (mem_addr !== a) addr_ok = 0;
      end
      if (mem_we_n === 1'b0) begin we_n++; last_we = busy; end
      if (mem_oe_n === 1'b0) begin oe_n++; last_oe = busy; end
      if (mem_dq_oe === 1'b1) begin
        dq_n++; last_dq = busy;
        if (mem_dq_out !== d) dq_ok = 0;
      end
      if (mem_oe_n === 1'b0 && mem_dq_oe === 1'b1) conflict = 1;
      if (rsp_valid === 1'b1) begin rsp_n++; rsp_at = busy; got = rsp_rdata; end
      busy++;
      @(negedge clk);
    end while (req_ready !== 1'b1 && busy < 100);
    chk(first_ok, "R4 settle phase first", int'(first_ok), 1);
    chk(addr_ok && pair_ok, "R3/R2 address and selects", int'(addr_ok && pair_ok), 1);
    chk(!conflict, "R7 bus conflict", int'(conflict), 0);
    if (wr) begin
      chk(busy == WR_BUSY, "R9 write busy cycles", busy, WR_BUSY);
      chk(sel_n == S + P + 1, "R4 write select cycles", sel_n, S + P + 1);
      chk(we_n == P && oe_n == 0, "R5 write pulse cycles", we_n, P);
      chk(dq_n == P + 1 && dq_ok, "R6 drive cycles", dq_n, P + 1);
      chk(last_dq == last_we + 1 && last_sel == last_dq, "R6 guard order", last_dq, last_we + 1);
      chk(rsp_n == 0, "R8 no write response", rsp_n, 0);
    end else begin
      chk(busy == RD_BUSY, "R9 read busy cycles", busy, RD_BUSY);
      chk(sel_n == S + A, "R4 read select cycles", sel_n, S + A);
      chk(oe_n == A && we_n == 0 && dq_n == 0, "R7 read enable cycles", oe_n, A);
      chk(rsp_n == 1 && rsp_at == last_oe + 1, "R8 response timing", rsp_at, last_oe + 1);
      chk(got === d, "R8 read data", int'(got), int'(d));
    end
  endtask

  task automatic run_txn(input bit wr, input logic [12:0] a, input logic [7:0] d);
    @(negedge clk);
    chk(req_ready === 1'b1, "R2 ready before request", int'(req_ready), 1);
    issue(wr, a, d);
    @(negedge clk);
    observe(wr, a, d);
  endtask

  // {write, address, data (write value or expected read value)}
  localparam logic [21:0] VEC [9] = '{
    {1'b1, 13'h0000, 8'h3C}, {1'b1, 13'h1FFF, 8'hC3},
    {1'b0, 13'h0000, 8'h3C}, {1'b0, 13'h1FFF, 8'hC3},
    {1'b1, 13'h0AA5, 8'h00}, {1'b1, 13'h0AA5, 8'hFF},
    {1'b0, 13'h0AA5, 8'hFF}, {1'b1, 13'h1555, 8'h5A},
    {1'b0, 13'h1555, 8'h5A}
  };

  initial begin
    repeat (20000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int wait_n;
    logic [7:0] got;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(mem_ce_n === 1 && mem_ce === 0 && mem_oe_n === 1 && mem_we_n === 1
        && mem_dq_oe === 0 && rsp_valid === 0 && req_ready === 1,
        "R1 reset state", int'(mem_ce_n), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready === 1 && mem_ce === 0 && mem_dq_oe === 0, "R1 after release",
        int'(req_ready), 1);

    foreach (VEC[i]) run_txn(VEC[i][21], VEC[i][20:8], VEC[i][7:0]);

    // R2 R9 R8: request held pending across a read.
    @(negedge clk);
    issue(1'b0, 13'h1FFF, 8'h00);
    @(negedge clk);
    issue(1'b1, 13'h0123, 8'h77);
    wait_n = 0; got = 8'h00;
    while (req_ready !== 1'b1 && wait_n < 100) begin
      if (rsp_valid === 1'b1) got = rsp_rdata;
      wait_n++;
      @(negedge clk);
    end
    chk(wait_n == RD_BUSY, "R2 held request waits", wait_n, RD_BUSY);
    chk(got === 8'hC3, "R8 data with request pending", int'(got), 8'hC3);
    @(negedge clk);
    observe(1'b1, 13'h0123, 8'h77);
    run_txn(1'b0, 13'h0123, 8'h77);

    // R1: reset in the middle of a write pulse.
    @(negedge clk);
    issue(1'b1, 13'h0042, 8'h99);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (S) @(negedge clk);
    chk(mem_we_n === 1'b0, "R5 pulse active before reset", int'(mem_we_n), 0);
    rst_n = 1'b0;
    #1;
    chk(mem_we_n === 1 && mem_ce === 0 && mem_ce_n === 1 && mem_dq_oe === 0
        && req_ready === 1, "R1 reset mid write", int'(mem_dq_oe), 0);
    @(negedge clk);
    rst_n = 1'b1;
    run_txn(1'b0, 13'h1555, 8'h5A);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule